// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block divides a source clock down to the 16x oversampling tick that a UART receiver and transmitter use. Every character bit is split into 16 sub-slots. Each sub-slot normally lasts a programmed integer number of source clocks. A 16-bit stretch mask can lengthen chosen sub-slots by one extra clock. The average bit period can therefore be tuned in steps of one sixteenth of the integer divisor, with no phase accumulator.

Software sets the full divisor as source rate divided by baud rate. The divisor field is written with that value divided by 16, minus one. The low four bits of the full divisor give the number of sixteenths, and that count sets how many mask bits are set. Spreading the set bits evenly keeps the jitter low: for example 0x0808 for two sixteenths and 0x5555 for eight. The mode parameter can build a legacy variant without a mask. In that variant the divisor alone sets the rate, and software rounds it to the nearest value.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset `tick` is 0 and `slot_idx` is 0.
- R2: In fractional mode, sub-slot i lasts (divisor + 1) source clocks while enabled, plus one clock when bit i of the active mask is 1.
- R3: `tick` is high for exactly the last clock of each sub-slot. During that clock `slot_idx` shows the index of the sub-slot that is ending. The index advances 0,1,…,15 and then wraps to 0.
- R4: A divisor of 0 with an all-zero mask gives a tick on every enabled source clock.
- R5: A divisor or mask write made while enabled does not change the sub-slot in progress. It applies from the next sub-slot onward.
- R6: While `en` is low, no tick is produced and the slot counters are cleared, so the first sub-slot after enabling is slot 0. Values written while disabled apply to that first sub-slot.
- R7: In legacy mode (`MODE` = `MODE_LEGACY`), mask writes are ignored and every sub-slot lasts divisor + 1 clocks.
- R8: One full rotation of 16 sub-slots lasts 16·(divisor+1) plus the number of set mask bits, in source clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low clears the counters |
| wr_div_en | input | 1 | Write strobe for the integer divisor |
| wr_div | input | DIV_W | Divisor value (sub-slot length minus one) |
| wr_mask_en | input | 1 | Write strobe for the stretch mask |
| wr_mask | input | NUM_SLOTS | Stretch mask; bit i lengthens sub-slot i |
| tick | output | 1 | One-clock pulse at the end of each sub-slot |
| slot_idx | output | $clog2(NUM_SLOTS) | Index of the current sub-slot |

## Verification
The bench builds the block twice with a 4-bit divisor and 16 slots: once in fractional mode and once in legacy mode. With the divisor this small, every value 0 to 3 can be swept against all sixteen fractional counts, using evenly spread masks and the recommended fixed masks, over two full slot rotations each. Directed sequences then cover a write made mid sub-slot, disabling in the middle of a rotation, and a write made while disabled.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

   typedef enum logic {
      MODE_LEGACY = 1'b0,
      MODE_FRAC   = 1'b1
   } frac_mode_e;

   // Width of a counter that must hold divisor + 1.
   function automatic int unsigned cnt_width(input int unsigned div_w);
      return div_w + 1;
   endfunction

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
   import frac_baud_pkg::*;
#(
   parameter int unsigned DIV_W     = 16,
   parameter int unsigned NUM_SLOTS = 16,
   parameter frac_mode_e  MODE      = MODE_FRAC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 boundary,
   input  logic                 wr_div_en,
   input  logic [DIV_W-1:0]     wr_div,
   input  logic                 wr_mask_en,
   input  logic [NUM_SLOTS-1:0] wr_mask,
   output logic [DIV_W-1:0]     act_div,
   output logic [NUM_SLOTS-1:0] act_mask
);

   logic             load_act;
   logic [DIV_W-1:0] pend_div;
   logic [DIV_W-1:0] div_nxt;

   assign load_act = !en || boundary;
   assign div_nxt  = wr_div_en ? wr_div : pend_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_div <= '0;
         act_div  <= '0;
      end else begin
         pend_div <= div_nxt;
         if (load_act) begin
            act_div <= div_nxt;
         end
      end
   end

   generate
      if (MODE == MODE_FRAC) begin : g_frac
         logic [NUM_SLOTS-1:0] pend_mask;
         logic [NUM_SLOTS-1:0] mask_nxt;

         assign mask_nxt = wr_mask_en ? wr_mask : pend_mask;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_mask <= '0;
               act_mask  <= '0;
            end else begin
               pend_mask <= mask_nxt;
               if (load_act) begin
                  act_mask <= mask_nxt;
               end
            end
         end

         AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !boundary) |=> $stable(act_mask)); // R5
      end else begin : g_legacy
         logic unused_mask_in;
         assign unused_mask_in = ^{wr_mask_en, wr_mask};
         assign act_mask = '0;
      end
   endgenerate

   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !boundary) |=> $stable(act_div)); // R5

endmodule

// File: rtl/frac_baud_cnt.sv
module frac_baud_cnt
   import frac_baud_pkg::*;
#(
   parameter int unsigned DIV_W     = 16,
   parameter int unsigned NUM_SLOTS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic [DIV_W-1:0]             act_div,
   input  logic [NUM_SLOTS-1:0]         act_mask,
   output logic                         tick,
   output logic [$clog2(NUM_SLOTS)-1:0] slot_idx
);

   localparam int unsigned IDX_W = $clog2(NUM_SLOTS);
   localparam int unsigned CNT_W = cnt_width(DIV_W);

   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] slot_q;
   logic             stretch;
   logic [CNT_W-1:0] limit;

   assign stretch  = act_mask[slot_q];
   assign limit    = {1'b0, act_div} + {{DIV_W{1'b0}}, stretch};
   assign tick     = en && (cnt_q == limit);
   assign slot_idx = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         slot_q <= '0;
      end else if (!en) begin
         cnt_q  <= '0;
         slot_q <= '0;
      end else if (tick) begin
         cnt_q  <= '0;
         slot_q <= slot_q + 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ({1'b0, act_div} + 1'b1)); // R2

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> slot_q == IDX_W'($past(slot_q) + 1'b1)); // R3

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (slot_q == '0) && (cnt_q == '0)); // R6

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frac_baud_pkg::*;
#(
   parameter int unsigned DIV_W     = 16,
   parameter int unsigned NUM_SLOTS = 16,
   parameter frac_mode_e  MODE      = MODE_FRAC
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         wr_div_en,
   input  logic [DIV_W-1:0]             wr_div,
   input  logic                         wr_mask_en,
   input  logic [NUM_SLOTS-1:0]         wr_mask,
   output logic                         tick,
   output logic [$clog2(NUM_SLOTS)-1:0] slot_idx
);

   generate
      if (DIV_W < 1 || DIV_W > 31) begin : g_bad_div
         $error("frac_baud_gen: DIV_W must lie in 1..31");
      end
      if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("frac_baud_gen: NUM_SLOTS must be a power of two >= 2");
      end
   endgenerate

   logic [DIV_W-1:0]     act_div;
   logic [NUM_SLOTS-1:0] act_mask;
   logic                 tick_int;

   frac_baud_regs #(
      .DIV_W     (DIV_W),
      .NUM_SLOTS (NUM_SLOTS),
      .MODE      (MODE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .boundary   (tick_int),
      .wr_div_en  (wr_div_en),
      .wr_div     (wr_div),
      .wr_mask_en (wr_mask_en),
      .wr_mask    (wr_mask),
      .act_div    (act_div),
      .act_mask   (act_mask)
   );

   frac_baud_cnt #(
      .DIV_W     (DIV_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .act_div  (act_div),
      .act_mask (act_mask),
      .tick     (tick_int),
      .slot_idx (slot_idx)
   );

   assign tick = tick_int;

   AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!en) && !en |-> !tick && slot_idx == '0); // R6

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
   import frac_baud_pkg::*;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned DIV_W      = 4;
   localparam int unsigned NUM_SLOTS  = 16;
   localparam int unsigned IDX_W      = $clog2(NUM_SLOTS);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 en = 1'b0;
   logic                 wr_div_en = 1'b0;
   logic [DIV_W-1:0]     wr_div = '0;
   logic                 wr_mask_en = 1'b0;
   logic [NUM_SLOTS-1:0] wr_mask = '0;
   logic                 tick_f, tick_l;
   logic [IDX_W-1:0]     slot_f, slot_l;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_baud_gen #(.DIV_W(DIV_W), .NUM_SLOTS(NUM_SLOTS), .MODE(MODE_FRAC)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .wr_div_en(wr_div_en), .wr_div(wr_div),
      .wr_mask_en(wr_mask_en), .wr_mask(wr_mask),
      .tick(tick_f), .slot_idx(slot_f));

   frac_baud_gen #(.DIV_W(DIV_W), .NUM_SLOTS(NUM_SLOTS), .MODE(MODE_LEGACY)) u_dut_leg (
      .clk(clk), .rst_n(rst_n), .en(en),
      .wr_div_en(wr_div_en), .wr_div(wr_div),
      .wr_mask_en(wr_mask_en), .wr_mask(wr_mask),
      .tick(tick_l), .slot_idx(slot_l));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NUM_SLOTS-1:0] spread(input int f);
      logic [NUM_SLOTS-1:0] m = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (((i + 1) * f) / NUM_SLOTS > (i * f) / NUM_SLOTS) m[i] = 1'b1;
      end
      return m;
   endfunction

   // Program while disabled, enable, and follow nticks sub-slots.
   task automatic run_cfg(input int div, input logic [NUM_SLOTS-1:0] mask,
                          input int nticks, input bit legacy, input string req);
      int k = 0;
      int in_slot = 0;
      int total = 0;
      int pop = 0;
      @(negedge clk);
      en = 1'b0; wr_div = DIV_W'(div); wr_div_en = 1'b1;
      wr_mask = mask; wr_mask_en = 1'b1;
      @(negedge clk);
      wr_div_en = 1'b0; wr_mask_en = 1'b0; en = 1'b1;
      for (int i = 0; i < NUM_SLOTS; i++) pop += (legacy ? 0 : int'(mask[i]));
      while (k < nticks) begin
         int len;
         bit exp_t;
         logic t;
         logic [IDX_W-1:0] s;
         #1;
         t = legacy ? tick_l : tick_f;
         s = legacy ? slot_l : slot_f;
         len = div + 1 + (legacy ? 0 : int'(mask[k % NUM_SLOTS]));
         exp_t = (in_slot == len - 1);
         total++;
         if (t !== exp_t) check(req, int'(t), int'(exp_t), "tick");
         if (exp_t) begin
            check(req, int'(t), 1, "tick at sub-slot end (R2)");
            check("R3", int'(s), k % NUM_SLOTS, "slot index");
            k++;
            in_slot = 0;
            if (k == NUM_SLOTS)
               check("R8", total, NUM_SLOTS * (div + 1) + pop, "rotation length");
         end else begin
            in_slot++;
         end
         @(negedge clk);
      end
      en = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(tick_f), 0, "tick in reset");
      check("R1", int'(slot_f), 0, "slot in reset");
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1", int'(tick_f), 0, "tick after reset");
      check("R1", int'(slot_f), 0, "slot after reset");

      // R4: divisor 0, no mask -> tick every clock
      @(negedge clk);
      wr_div = '0; wr_div_en = 1'b1; wr_mask = '0; wr_mask_en = 1'b1;
      @(negedge clk);
      wr_div_en = 1'b0; wr_mask_en = 1'b0; en = 1'b1;
      for (int c = 0; c < 20; c++) begin
         #1;
         check("R4", int'(tick_f), 1, "tick every clock");
         check("R4", int'(slot_f), c % NUM_SLOTS, "slot every clock");
         @(negedge clk);
      end
      en = 1'b0;
      @(negedge clk);

      // R2/R3/R8 sweep in fractional mode
      for (int d = 0; d < 4; d++) begin
         for (int f = 0; f < NUM_SLOTS; f++) begin
            run_cfg(d, spread(f), 2 * NUM_SLOTS, 1'b0, "R2");
         end
      end
      run_cfg(2, 16'h0080, NUM_SLOTS, 1'b0, "R2");
      run_cfg(2, 16'h0808, NUM_SLOTS, 1'b0, "R2");
      run_cfg(2, 16'h2222, NUM_SLOTS, 1'b0, "R2");
      run_cfg(2, 16'h5555, NUM_SLOTS, 1'b0, "R2");
      run_cfg(2, 16'hDDDD, NUM_SLOTS, 1'b0, "R2");
      run_cfg(2, 16'hFFDF, NUM_SLOTS, 1'b0, "R2");

      // R7: legacy mode ignores a full mask
      for (int d = 0; d < 4; d++) begin
         run_cfg(d, 16'hFFFF, 2 * NUM_SLOTS, 1'b1, "R7");
      end

      // R5: divisor write in the middle of a sub-slot
      @(negedge clk);
      wr_div = 4'd2; wr_div_en = 1'b1; wr_mask = '0; wr_mask_en = 1'b1;
      @(negedge clk);
      wr_div_en = 1'b0; wr_mask_en = 1'b0; en = 1'b1;
      for (int c = 0; c < 20; c++) begin
         bit exp_t;
         #1;
         exp_t = (c == 2) || (c == 8) || (c == 14);
         check("R5", int'(tick_f), int'(exp_t), $sformatf("tick at cycle %0d", c));
         if (c == 8) check("R5", int'(slot_f), 1, "slot after late write");
         @(negedge clk);
         if (c == 0) begin wr_div = 4'd5; wr_div_en = 1'b1; end
         else wr_div_en = 1'b0;
      end
      en = 1'b0;
      @(negedge clk);

      // R6: disable mid rotation, write while disabled, re-enable
      wr_div = 4'd1; wr_div_en = 1'b1;
      @(negedge clk);
      wr_div_en = 1'b0; en = 1'b1;
      repeat (5) @(negedge clk);
      en = 1'b0;
      for (int c = 0; c < 3; c++) begin
         #1;
         check("R6", int'(tick_f), 0, "no tick while disabled");
         @(negedge clk);
         if (c == 0) begin wr_div = 4'd3; wr_div_en = 1'b1; end
         else wr_div_en = 1'b0;
      end
      en = 1'b1;
      for (int c = 0; c < 4; c++) begin
         #1;
         check("R6", int'(tick_f), (c == 3) ? 1 : 0, $sformatf("re-enable cycle %0d", c));
         if (c == 3) check("R6", int'(slot_f), 0, "slot restarts at 0");
         @(negedge clk);
      end
      en = 1'b0;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule